// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of upcoming instruction bytes between a memory port and an execution unit. While the execution unit is busy, the fetch side reads ahead from ascending addresses, normally two bytes per memory access. The consumer takes one byte per pop, in address order.

A fresh memory request is raised only when the queue has at least two free byte slots. This keeps a returning word from ever overflowing the store. Only one request is outstanding at a time.

A flush, used on a taken branch, empties the queue and loads a new fetch address. Any response still owed for a fetch issued before the flush is dropped. When the new address is odd, the first access fetches a single byte, so every later access is word aligned.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`byte_valid` low), and the block requests address 0.
- R2: The queue holds exactly six bytes. With no pops, fetching stops once six bytes are stored, and six pops then drain it.
- R3: Popped bytes appear on `byte_out` in ascending address order, starting at the last flush address. The head byte holds steady while it is not popped.
- R4: A request to an even address has `mem_two` high. The response carries the byte at that address in `mem_rdata[7:0]` and the next address's byte in `mem_rdata[15:8]`.
- R5: `mem_req` is raised only when at least two byte slots are free. With one free slot, no request is made.
- R6: Once raised, `mem_req` and `mem_addr` stay unchanged until `mem_ready` is seen high or a flush occurs.
- R7: After an accepted two-byte fetch, the next request address is the previous one plus 2.
- R8: A pop while `byte_valid` is low is ignored. No byte is consumed, and the next stored byte is the one expected.
- R9: A pop and a returning response in the same cycle both take effect, with no byte lost or repeated.
- R10: `flush` empties the queue in the next cycle and loads `flush_addr`. A response owed from before the flush is discarded.
- R11: A request to an odd address has `mem_two` low. Its single byte arrives in `mem_rdata[7:0]`, and the following request is to the next (even) address.
- R12: At most one fetch is outstanding. From an accepted request until its response, `mem_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty queue and restart fetching at `flush_addr` |
| flush_addr | input | AW | New fetch address on flush |
| pop | input | 1 | Consume the head byte |
| byte_valid | output | 1 | Head byte is present |
| byte_out | output | 8 | Head byte |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | AW | Fetch address |
| mem_two | output | 1 | 1: two-byte fetch, 0: single byte |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Response data valid |
| mem_rdata | input | 16 | Response data, lower address in bits 7:0 |

## Verification
Two events can land in the same cycle: a response writing one or two bytes at the tail, and a pop removing the head. This is provoked with back-to-back pops against a memory with zero or short latency, so arrivals and pops overlap again and again. The overlap is judged by comparing every popped byte against the address-derived expected value; any miscount shows up as a skipped or repeated byte.

A second overlap is a flush while a response is still owed. A long-latency fetch is issued, then a flush is applied before the data returns. The bench checks that the first bytes popped afterwards belong to the new address.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          pop,
  output logic          byte_valid,
  output logic [7:0]    byte_out,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_two,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] fetch_addr;
  logic          busy, stale, pend_two;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic push, do_pop, accept;
  assign push   = mem_rvalid && busy && !stale && !flush;
  assign do_pop = pop && byte_valid && !flush;

  assign byte_valid = count != '0;
  assign byte_out   = q[rd_ptr];
  assign mem_req    = !busy && !flush && ((CW'(DEPTH) - count) >= CW'(2));
  assign mem_addr   = fetch_addr;
  assign mem_two    = !fetch_addr[0];
  assign accept     = mem_req && mem_ready;

  always_ff @(posedge clk) begin
    if (push) begin
      q[wr_ptr] <= mem_rdata[7:0];
      if (pend_two) q[nxt(wr_ptr)] <= mem_rdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      count      <= '0;
      fetch_addr <= '0;
      busy       <= 1'b0;
      stale      <= 1'b0;
      pend_two   <= 1'b0;
    end else if (flush) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      count      <= '0;
      fetch_addr <= flush_addr;
      busy       <= busy && !mem_rvalid;
      stale      <= busy && !mem_rvalid;
    end else begin
      if (accept) begin
        busy       <= 1'b1;
        pend_two   <= mem_two;
        fetch_addr <= fetch_addr + (mem_two ? AW'(2) : AW'(1));
      end else if (busy && mem_rvalid) begin
        busy  <= 1'b0;
        stale <= 1'b0;
      end
      if (push) wr_ptr <= pend_two ? nxt(nxt(wr_ptr)) : nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      count <= count + (push ? (pend_two ? CW'(2) : CW'(1)) : CW'(0))
                     - (do_pop ? CW'(1) : CW'(0));
    end
  end

  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (flush || (mem_req && $stable(mem_addr))));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_addr == $past(mem_addr) + ($past(mem_two) ? AW'(2) : AW'(1))));

  // R11
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mem_two) |=> !mem_addr[0]);

  // R12
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_req);

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !pop && !flush) |=> (byte_valid && $stable(byte_out)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !byte_valid);

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid && !mem_rvalid && !flush) |=> !byte_valid);
endmodule

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NV = 5;
  // {start addr, ready pattern, pop pattern, latency, bytes to consume}
  localparam logic [43:0] VEC [NV] = '{
    {16'h0000, 8'hFF, 8'hFF, 4'd0, 8'd20},
    {16'h1235, 8'hAA, 8'hFF, 4'd1, 8'd16},
    {16'h2000, 8'hFF, 8'h11, 4'd0, 8'd16},
    {16'h3001, 8'h37, 8'hB5, 4'd3, 8'd16},
    {16'hFFFC, 8'hFF, 8'hFF, 4'd2, 8'd12}
  };

  logic clk = 0, rst_n = 0, flush = 0, pop = 0;
  logic [AW-1:0] flush_addr = '0;
  logic byte_valid, mem_req, mem_two;
  logic [7:0] byte_out;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 0, mem_rvalid = 0;
  logic [15:0] mem_rdata = '0;

  prefetch_queue #(.DEPTH(6), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .pop(pop), .byte_valid(byte_valid), .byte_out(byte_out),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_two(mem_two),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, consumed = 0;
  logic [7:0] rdy_pat = 0, pop_pat = 0;
  logic [3:0] cur_lat = 0, lat_cnt = 0;
  bit auto_pop = 0, man_req = 0, force_pop = 0;
  bit acc = 0, inflight = 0, model_busy = 0, prev_hold = 0;
  bit acc_two, rsp_two;
  logic [AW-1:0] acc_addr, rsp_addr, prev_addr;
  logic [AW-1:0] exp_addr = '0, exp_fetch = '0;
  string cur_req = "R3";

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
    if (rst_n) begin
      if (model_busy) chk(!mem_req, "R12", mem_req, 0);
      if (prev_hold && !flush) chk(mem_req && mem_addr == prev_addr, "R6", mem_addr, prev_addr);
      prev_hold = mem_req && !mem_ready && !flush;
      prev_addr = mem_addr;
      if (mem_rvalid) model_busy = 0;
      if (mem_req && mem_ready) begin
        chk(mem_addr == exp_fetch, "R7", mem_addr, exp_fetch);
        chk(mem_two == !exp_fetch[0], exp_fetch[0] ? "R11" : "R4", mem_two, !exp_fetch[0]);
        exp_fetch = exp_fetch + (exp_fetch[0] ? 16'd1 : 16'd2);
        acc = 1; acc_addr = mem_addr; acc_two = mem_two; model_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (!rst_n) begin
      inflight = 0; pop = 0;
    end else begin
      mem_ready = rdy_pat[cyc[2:0]];
      if (inflight) begin
        if (lat_cnt == 0) begin
          mem_rvalid = 1;
          mem_rdata = rsp_two ? {fb(rsp_addr + 16'd1), fb(rsp_addr)} : {8'hEE, fb(rsp_addr)};
          inflight = 0;
        end else lat_cnt--;
      end
      if (acc) begin
        inflight = 1; lat_cnt = cur_lat; rsp_addr = acc_addr; rsp_two = acc_two; acc = 0;
      end
      pop = force_pop | (auto_pop ? pop_pat[cyc[2:0]] : man_req);
      if (pop && byte_valid && !flush) begin
        chk(byte_out == fb(exp_addr), cur_req, byte_out, fb(exp_addr));
        exp_addr++;
        consumed++;
        man_req = 0;
      end
    end
  end

  task automatic do_flush(input logic [AW-1:0] a);
    @(posedge clk); #1;
    flush = 1; flush_addr = a; exp_addr = a; exp_fetch = a;
    @(posedge clk); #1;
    flush = 0;
    chk(!byte_valid, "R10", byte_valid, 0);
  endtask

  task automatic pop_one();
    int t = 0;
    man_req = 1;
    do begin @(posedge clk); #1; t++; end while (man_req && t < 50);
    chk(!man_req, "R8", man_req, 0);
    man_req = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!byte_valid, "R1", byte_valid, 0);
    chk(mem_req, "R1", mem_req, 1);
    chk(mem_addr == 0, "R1", mem_addr, 0);

    // table walk: streaming, odd starts, slow consumer, address wrap (R9)
    for (int i = 0; i < NV; i++) begin
      int t = 0;
      cur_req = (i == 0) ? "R9" : "R3";
      rdy_pat = VEC[i][27:20]; pop_pat = VEC[i][19:12]; cur_lat = VEC[i][11:8];
      auto_pop = 0;
      do_flush(VEC[i][43:28]);
      consumed = 0; auto_pop = 1;
      while (consumed < int'(VEC[i][7:0]) && t < 3000) begin wait_cyc(1); t++; end
      chk(consumed >= int'(VEC[i][7:0]), "R3", consumed, VEC[i][7:0]);
      auto_pop = 0;
    end

    // capacity and refill policy
    cur_req = "R2"; rdy_pat = 8'hFF; cur_lat = 1;
    do_flush(16'h0100);
    wait_cyc(40);
    chk(!mem_req, "R2", mem_req, 0);
    chk(byte_valid, "R2", byte_valid, 1);
    rdy_pat = 0;
    pop_one();
    wait_cyc(3);
    chk(!mem_req, "R5", mem_req, 0);
    pop_one();
    wait_cyc(2);
    chk(mem_req, "R5", mem_req, 1);
    chk(mem_addr == 16'h0106, "R7", mem_addr, 16'h0106);
    for (int k = 0; k < 4; k++) pop_one();
    wait_cyc(2);
    chk(!byte_valid, "R2", byte_valid, 0);

    // pop while empty is ignored
    cur_req = "R8";
    force_pop = 1;
    wait_cyc(3);
    force_pop = 0;
    chk(!byte_valid, "R8", byte_valid, 0);
    rdy_pat = 8'hFF;
    pop_one();
    pop_one();

    // flush with a fetch still owed
    cur_req = "R10"; cur_lat = 12;
    do_flush(16'h0300);
    begin
      int t = 0;
      do begin @(posedge clk); #1; t++; end while (!model_busy && t < 50);
    end
    wait_cyc(2);
    cur_lat = 2;
    do_flush(16'h0400);
    consumed = 0; pop_pat = 8'hFF; auto_pop = 1;
    begin
      int t = 0;
      while (consumed < 10 && t < 2000) begin wait_cyc(1); t++; end
    end
    chk(consumed >= 10, "R10", consumed, 10);
    auto_pop = 0;

    wait_cyc(5);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule